// File: doc/BRIEF.md
# Automatic Software Flow-Control Inserter

This block sits between a UART receiver's FIFO and its transmitter. It watches how full the receive FIFO is and puts stop and resume characters into the outgoing serial stream on its own, so the far end pauses before the FIFO overruns. The block also raises a receive-threshold interrupt. A stop is sent as two programmable characters, and a resume is sent the same way.

A 2-bit selector picks one of four fill thresholds. Each threshold has its own lower resume level, and that gap gives the link its hysteresis. A stop is not sent as soon as the threshold is reached. The block waits for two character-time ticks first, and if the FIFO drains far enough during that wait, the stop is dropped. The transmitter sees one valid/ready port. Flow characters win over ordinary transmit data, and the two characters of a pair always go out back to back.

The character-time tick comes from outside the block and is one clock wide, one pulse per character time. The FIFO storage, the shift registers, the baud generator and the recognition of incoming flow characters all live outside this block.

Top module: `swFlowGen`

## Requirements
- R1: `rxIntr` is low after reset. One clock after `rxCount` is sampled, `rxIntr` shows whether that count is at or above the selected threshold. `trigSel` values 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 characters.
- R2: Once the count is at or above the threshold, a stop request appears on the transmit port only after two `charTick` pulses have been sampled. The request shows on `txValid` one clock after the edge that samples the second pulse, and not before.
- R3: A stop is sent as `stopChar1` and then `stopChar2`. A resume is sent as `goChar1` and then `goChar2`.
- R4: While stopped, the resume pair is requested once `rxCount` is at or below the resume level for the selected threshold. The resume levels are 0, 1, 4 and 8 for `trigSel` values 0 to 3. Any count above that level sends nothing.
- R5: After a stop pair has been sent, no further stop pair is sent until a resume pair has gone out. A resume pair is sent only after a stop pair.
- R6: If `rxCount` falls to the resume level or lower during the two-tick wait, the pending stop is cancelled and no character is sent.
- R7: While a flow character is requested, `dataReady` is low and the flow character is on `txData`. No data byte is accepted between the two characters of a pair.
- R8: While a flow request waits with `txReady` low, `txValid` stays high and `txData` does not change.
- R9: Driving `enable` low removes any flow request at once and returns the block to its running state. After that, no resume pair is owed.
- R10: With no flow request, `txValid` equals `dataValid`, `txData` equals `dataByte`, and `dataReady` equals `txReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Turns automatic flow control on |
| trigSel | input | 2 | Threshold select (1/4/8/14) |
| rxCount | input | CNT_W | Current receive FIFO fill count |
| charTick | input | 1 | One-clock pulse per character time |
| stopChar1 | input | CHAR_W | First stop character |
| stopChar2 | input | CHAR_W | Second stop character |
| goChar1 | input | CHAR_W | First resume character |
| goChar2 | input | CHAR_W | Second resume character |
| dataValid | input | 1 | Ordinary transmit byte is offered |
| dataByte | input | CHAR_W | Ordinary transmit byte |
| dataReady | output | 1 | Ordinary byte taken this cycle |
| txValid | output | 1 | A character is offered to the transmitter |
| txData | output | CHAR_W | Character offered to the transmitter |
| txReady | input | 1 | Transmitter takes the offered character |
| rxIntr | output | 1 | Receive threshold reached |

## Verification
`rxIntr` is due one clock after `rxCount` changes. A stop request is due one clock after the edge that samples the second tick. Resume requests, cancellation and the return to idle on disable each settle one clock after the input that causes them. The port pass-through and the blocking of data are combinational and hold in the same cycle. The bench drives inputs just after a rising edge and samples on the falling edge. Each timed check therefore waits for the exact number of rising edges above, and it also checks the cycle just before the output is due. A monitor compares every accepted flow character against a queue of expected ones, and it flags any data byte accepted between the two halves of a pair.

// File: rtl/swFlowPkg.sv
package swFlowPkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_ARM   = 3'd1,
    ST_STOP1 = 3'd2,
    ST_STOP2 = 3'd3,
    ST_HALT  = 3'd4,
    ST_GO1   = 3'd5,
    ST_GO2   = 3'd6
  } flowState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic flowReq;    // a flow character is wanted on the port
    logic pickStop;   // stop pair (1) or resume pair (0)
    logic pickSecond; // second character of the pair
    logic armClr;     // hold the character-time counter at zero
  } flowCmd_t;

  function automatic int trigLevel(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int resumeLevel(input logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 1;
      2'd2:    return 4;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/swFlowDp.sv
module swFlowDp
  import swFlowPkg::*;
#(
  parameter int CHAR_W      = 8,
  parameter int CNT_W       = 5,
  parameter int DELAY_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        trigSel,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              charTick,
  input  logic [CHAR_W-1:0] stopChar1,
  input  logic [CHAR_W-1:0] stopChar2,
  input  logic [CHAR_W-1:0] goChar1,
  input  logic [CHAR_W-1:0] goChar2,
  input  logic              dataValid,
  input  logic [CHAR_W-1:0] dataByte,
  input  logic              txReady,
  input  flowCmd_t          cmd,
  output logic              aboveTrig,
  output logic              atResume,
  output logic              delayDone,
  output logic              txValid,
  output logic [CHAR_W-1:0] txData,
  output logic              dataReady,
  output logic              rxIntr
);

  localparam int TICK_W = $clog2(DELAY_TICKS + 1);

  logic [CNT_W-1:0]  trigVal;
  logic [CNT_W-1:0]  resumeVal;
  logic [TICK_W-1:0] tickCnt;
  logic [CHAR_W-1:0] flowChar;
  logic              flowLive;

  always_comb begin
    trigVal   = CNT_W'(trigLevel(trigSel));
    resumeVal = CNT_W'(resumeLevel(trigSel));
    aboveTrig = (rxCount >= trigVal);
    atResume  = (rxCount <= resumeVal);
    delayDone = (tickCnt >= TICK_W'(DELAY_TICKS));
  end

  // character-time counter for the stop delay
  always_ff @(posedge clk) begin
    if (!rstN || cmd.armClr) begin
      tickCnt <= '0;
    end else if (charTick && !delayDone) begin
      tickCnt <= tickCnt + TICK_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rxIntr <= 1'b0;
    else       rxIntr <= aboveTrig;
  end

  always_comb begin
    case ({cmd.pickStop, cmd.pickSecond})
      2'b10:   flowChar = stopChar1;
      2'b11:   flowChar = stopChar2;
      2'b00:   flowChar = goChar1;
      default: flowChar = goChar2;
    endcase
  end

  // port mux: flow characters have priority over ordinary data
  always_comb begin
    flowLive  = cmd.flowReq & enable;
    txValid   = flowLive | dataValid;
    txData    = flowLive ? flowChar : dataByte;
    dataReady = txReady & ~flowLive;
  end

endmodule

// File: rtl/swFlowCtl.sv
module swFlowCtl
  import swFlowPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     aboveTrig,
  input  logic     atResume,
  input  logic     delayDone,
  input  logic     txReady,
  output flowCmd_t cmd
);

  flowState_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    if (!enable) begin
      stateNxt = ST_RUN;
    end else begin
      case (state)
        ST_RUN:   if (aboveTrig) stateNxt = ST_ARM;
        ST_ARM: begin
          if (atResume)       stateNxt = ST_RUN;
          else if (delayDone) stateNxt = ST_STOP1;
        end
        ST_STOP1: if (txReady)  stateNxt = ST_STOP2;
        ST_STOP2: if (txReady)  stateNxt = ST_HALT;
        ST_HALT:  if (atResume) stateNxt = ST_GO1;
        ST_GO1:   if (txReady)  stateNxt = ST_GO2;
        ST_GO2:   if (txReady)  stateNxt = ST_RUN;
        default:                stateNxt = ST_RUN;
      endcase
    end
  end

  always_comb begin
    cmd.flowReq    = (state == ST_STOP1) || (state == ST_STOP2) ||
                     (state == ST_GO1)   || (state == ST_GO2);
    cmd.pickStop   = (state == ST_STOP1) || (state == ST_STOP2);
    cmd.pickSecond = (state == ST_STOP2) || (state == ST_GO2);
    cmd.armClr     = (state != ST_ARM);
  end

endmodule

// File: rtl/swFlowGen.sv
module swFlowGen
  import swFlowPkg::*;
#(
  parameter int CHAR_W      = 8,
  parameter int CNT_W       = 5,
  parameter int DELAY_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        trigSel,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              charTick,
  input  logic [CHAR_W-1:0] stopChar1,
  input  logic [CHAR_W-1:0] stopChar2,
  input  logic [CHAR_W-1:0] goChar1,
  input  logic [CHAR_W-1:0] goChar2,
  input  logic              dataValid,
  input  logic [CHAR_W-1:0] dataByte,
  output logic              dataReady,
  output logic              txValid,
  output logic [CHAR_W-1:0] txData,
  input  logic              txReady,
  output logic              rxIntr
);

  flowCmd_t cmd;
  logic     aboveTrig;
  logic     atResume;
  logic     delayDone;

  swFlowCtl ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .aboveTrig (aboveTrig),
    .atResume  (atResume),
    .delayDone (delayDone),
    .txReady   (txReady),
    .cmd       (cmd)
  );

  swFlowDp #(
    .CHAR_W      (CHAR_W),
    .CNT_W       (CNT_W),
    .DELAY_TICKS (DELAY_TICKS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .trigSel   (trigSel),
    .rxCount   (rxCount),
    .charTick  (charTick),
    .stopChar1 (stopChar1),
    .stopChar2 (stopChar2),
    .goChar1   (goChar1),
    .goChar2   (goChar2),
    .dataValid (dataValid),
    .dataByte  (dataByte),
    .txReady   (txReady),
    .cmd       (cmd),
    .aboveTrig (aboveTrig),
    .atResume  (atResume),
    .delayDone (delayDone),
    .txValid   (txValid),
    .txData    (txData),
    .dataReady (dataReady),
    .rxIntr    (rxIntr)
  );

endmodule

// File: rtl/swFlowChk.sv
module swFlowChk
  import swFlowPkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [1:0]        trigSel,
  input logic [CNT_W-1:0]  rxCount,
  input logic              rxIntr,
  input logic              dataValid,
  input logic [CHAR_W-1:0] dataByte,
  input logic              dataReady,
  input logic              txValid,
  input logic [CHAR_W-1:0] txData,
  input logic              txReady,
  input flowCmd_t          cmd
);

  logic live;
  always_ff @(posedge clk) begin
    if (!rstN) live <= 1'b0;
    else       live <= 1'b1;
  end

  a_r1_intr_level: assert property (@(posedge clk) disable iff (!rstN)
    live |-> (rxIntr == ($past(rxCount) >= CNT_W'(trigLevel($past(trigSel))))));

  a_r3_pair_order: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cmd.flowReq && txReady && !cmd.pickSecond) |=>
      (!enable || (cmd.flowReq && cmd.pickSecond && (cmd.pickStop == $past(cmd.pickStop)))));

  a_r7_flow_first: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cmd.flowReq) |-> (txValid && !dataReady));

  a_r8_hold_char: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cmd.flowReq && !txReady) |=> (!enable || (txValid && $stable(txData))));

  a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !cmd.flowReq);

  a_r10_pass_data: assert property (@(posedge clk) disable iff (!rstN)
    !(enable && cmd.flowReq) |->
      ((txValid == dataValid) && (dataReady == txReady) && (!dataValid || (txData == dataByte))));

endmodule

bind swFlowGen swFlowChk #(.CHAR_W(CHAR_W), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .trigSel   (trigSel),
  .rxCount   (rxCount),
  .rxIntr    (rxIntr),
  .dataValid (dataValid),
  .dataByte  (dataByte),
  .dataReady (dataReady),
  .txValid   (txValid),
  .txData    (txData),
  .txReady   (txReady),
  .cmd       (cmd)
);

// File: tb/swFlowGen_tb_top.sv
module swFlowGen_tb_top;

  localparam int CHAR_W = 8;
  localparam int CNT_W  = 5;

  localparam logic [7:0] S1 = 8'h13;
  localparam logic [7:0] S2 = 8'h93;
  localparam logic [7:0] G1 = 8'h11;
  localparam logic [7:0] G2 = 8'h91;
  localparam logic [7:0] DB = 8'h41;

  logic              clk = 1'b0;
  logic              rstN;
  logic              enable;
  logic [1:0]        trigSel;
  logic [CNT_W-1:0]  rxCount;
  logic              charTick;
  logic              dataValid;
  logic [CHAR_W-1:0] dataByte;
  logic              dataReady;
  logic              txValid;
  logic [CHAR_W-1:0] txData;
  logic              txReady;
  logic              rxIntr;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] expFlow[$];
  logic       midPair = 1'b0;

  always #5 clk = ~clk;

  swFlowGen #(.CHAR_W(CHAR_W), .CNT_W(CNT_W), .DELAY_TICKS(2)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .trigSel(trigSel),
    .rxCount(rxCount), .charTick(charTick),
    .stopChar1(S1), .stopChar2(S2), .goChar1(G1), .goChar2(G2),
    .dataValid(dataValid), .dataByte(dataByte), .dataReady(dataReady),
    .txValid(txValid), .txData(txData), .txReady(txReady), .rxIntr(rxIntr)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick();
    @(posedge clk); #1 charTick = 1'b1;
    @(posedge clk); #1 charTick = 1'b0;
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (expFlow.size() != 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check(expFlow.size() == 0, req, expFlow.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && txValid && txReady) begin
      if (!dataReady) begin
        if (expFlow.size() == 0) begin
          check(1'b0, "R5 unexpected flow char", txData, 0);
        end else begin
          logic [7:0] e;
          e = expFlow.pop_front();
          check(txData == e, "R3 flow char order", txData, e);
        end
        midPair = (txData == S1) || (txData == G1);
      end else begin
        check(!midPair, "R7 data inside pair", 1, 0);
        check(txData == dataByte, "R10 data passthrough", txData, dataByte);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; trigSel = 2'd0; rxCount = '0; charTick = 1'b0;
    dataValid = 1'b0; dataByte = DB; txReady = 1'b0;
    repeat (3) step();
    @(negedge clk);
    check(!txValid && !rxIntr, "R1 reset state", {txValid, rxIntr}, 0);
    step(); rstN = 1'b1;
    step();

    // R1: thresholds 1,4,8,14, one-cycle latency
    for (int s = 0; s < 4; s++) begin
      int lvl;
      lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      trigSel = 2'(s);
      rxCount = CNT_W'(lvl - 1);
      step(); @(negedge clk);
      check(!rxIntr, "R1 below threshold", rxIntr, 0);
      step(); rxCount = CNT_W'(lvl);
      @(negedge clk);
      check(!rxIntr, "R1 not before one clock", rxIntr, 0);
      @(posedge clk); @(negedge clk);
      check(rxIntr, "R1 at threshold", rxIntr, 1);
      step(); rxCount = '0;
    end

    // R2 delay, R8 hold, R3 order (threshold 4)
    trigSel = 2'd1; enable = 1'b1; step();
    rxCount = 5'd4; step();
    tick(); @(negedge clk);
    check(!txValid, "R2 nothing after one tick", txValid, 0);
    tick(); @(negedge clk);
    check(!txValid, "R2 not yet at counting edge", txValid, 0);
    @(posedge clk); @(negedge clk);
    check(txValid && txData == S1, "R2 stop request due", txData, S1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(txValid && txData == S1 && !dataReady, "R8 held under backpressure", txData, S1);
    expFlow.push_back(S1); expFlow.push_back(S2);
    step(); txReady = 1'b1;
    drain("R3 stop pair sent");

    // R5: no repeat stop; R4: above resume level sends nothing
    rxCount = 5'd10;
    repeat (4) tick();
    repeat (5) step();
    @(negedge clk);
    check(!txValid, "R5 no second stop pair", txValid, 0);
    rxCount = 5'd2;
    repeat (5) step();
    @(negedge clk);
    check(!txValid, "R4 above resume level", txValid, 0);
    expFlow.push_back(G1); expFlow.push_back(G2);
    step(); rxCount = 5'd1;
    drain("R4 resume at level 1");
    rxCount = 5'd0;
    repeat (6) step();
    @(negedge clk);
    check(!txValid, "R5 no resume without stop", txValid, 0);

    // R6: cancel during wait (threshold 8, resume 4)
    trigSel = 2'd2; rxCount = 5'd8; step();
    tick(); rxCount = 5'd4;
    repeat (3) tick();
    repeat (3) step();
    @(negedge clk);
    check(!txValid, "R6 stop cancelled", txValid, 0);

    // R7: priority over streaming data (threshold 14, resume 8)
    trigSel = 2'd3; dataValid = 1'b1; step();
    rxCount = 5'd14; step();
    tick();
    expFlow.push_back(S1); expFlow.push_back(S2);
    tick(); @(negedge clk);
    check(dataReady && txData == DB, "R10 data flows before stop", txData, DB);
    @(posedge clk); @(negedge clk);
    check(!dataReady && txData == S1, "R7 flow char wins", {dataReady, txData}, S1);
    drain("R7 stop pair amid data");
    rxCount = 5'd9; repeat (4) step();
    expFlow.push_back(G1); expFlow.push_back(G2);
    rxCount = 5'd8;
    drain("R4 resume at level 8");
    rxCount = 5'd0; dataValid = 1'b0; step();

    // R9: disable mid-request (threshold 1)
    trigSel = 2'd0; txReady = 1'b0; step();
    rxCount = 5'd1; step();
    tick(); tick();
    @(posedge clk); @(negedge clk);
    check(txValid && txData == S1, "R9 stop pending before disable", txData, S1);
    step(); enable = 1'b0;
    @(negedge clk);
    check(!txValid, "R9 request dropped at once", txValid, 0);
    dataValid = 1'b1; #1;
    check(txValid && txData == DB && !dataReady, "R10 data while disabled", txData, DB);
    step(); dataValid = 1'b0; rxCount = 5'd0;
    step(); enable = 1'b1;
    repeat (5) step();
    @(negedge clk);
    check(!txValid, "R9 no resume owed after disable", txValid, 0);

    // R4: threshold 1 / resume 0 full cycle
    txReady = 1'b1;
    expFlow.push_back(S1); expFlow.push_back(S2);
    rxCount = 5'd1; step();
    tick(); tick();
    drain("R3 stop pair at threshold 1");
    expFlow.push_back(G1); expFlow.push_back(G2);
    rxCount = 5'd0;
    drain("R4 resume at level 0");

    repeat (4) step();
    check(expFlow.size() == 0, "R5 no stray flow chars", expFlow.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule